// File: doc/BRIEF.md
# Compressed Instruction Code-Point Classifier

This block looks at one 16-bit halfword and sorts it into one of five classes: an ordinary instruction, a hint, a reserved encoding, a custom encoding, or the all-zero pattern that must always trap. The classification is purely combinational. It sits beside the compressed-instruction expander in a fetch or decode stage. A reserved or illegal result feeds the illegal-instruction trap decision. A hint result lets the pipeline retire the halfword as a no-op without trapping.

Most of the work lies in the operand fields rather than the opcode. The same row of the map can hold a real instruction, a hint and a reserved slot, and which one applies depends on a zero destination, a zero immediate, a zero source or one special register. A build parameter selects a 32-bit or 64-bit base, which changes how several rows are read.

Two side flags add detail to the hint class. One marks the shift forms whose operands make them useless. The other marks the add-to-x0 forms that carry a non-temporal locality level, and a 2-bit field gives that level. Halfwords that are the low part of a 32-bit instruction raise a separate flag and leave every class bit clear.

The block does not check whether floating-point loads and stores are allowed by the current extension state. It reports those rows as ordinary instructions.

Top module: `cpc_classify`

## Requirements
- R1: `category` is one-hot. Bit 0 means legal, bit 1 hint, bit 2 reserved, bit 3 custom and bit 4 illegal. Exactly one bit is set whenever `insn_hw[1:0]` is not 2'b11. When `insn_hw[1:0]` is 2'b11, `not_compressed` is 1 and `category`, `ntl_hint`, `ntl_level` and `shift_hint` are all zero. Otherwise `not_compressed` is 0.
- R2: The halfword 16'h0000 is classed illegal. No other halfword is classed illegal.
- R3: In quadrant 0 (bits [1:0]=00), every halfword in row bits[15:13]=100 is reserved. In row 000, a halfword with bits[12:5] all zero (and the whole halfword not zero) is reserved.
- R4: In quadrant 1, row 000 (add immediate), the 6-bit immediate is {bit 12, bits 6:2} and rd is bits 11:7. With rd=0 and a zero immediate the result is legal (the no-op). With rd=0 and a nonzero immediate the result is a hint. With rd≠0 and a zero immediate the result is a hint. All other cases are legal.
- R5: The following are hints, never reserved or illegal: load-immediate (quadrant 1, row 010) with rd=0; move (quadrant 2, row 100, bit 12=0) with rd=0 and rs2 (bits 6:2) nonzero; register add (quadrant 2, row 100, bit 12=1) with rd=0 and rs2 not in 0 or 2 to 5.
- R6: Register add with rd=0 and rs2 in 2 to 5 is a hint with `ntl_hint`=1 and `ntl_level`=rs2−2. In every other case both `ntl_hint` and `ntl_level` are 0.
- R7: Degenerate shifts are hints with `shift_hint`=1. These are the left shift (quadrant 2, row 000) with rd=0 or shamt={bit 12, bits 6:2}=0, and the right shifts (quadrant 1, row 100, bits 11:10 = 00 or 01) with shamt=0. `shift_hint` is 0 in every other case.
- R8: With XLEN=32, any of these three shifts with bit 12 set is custom. This takes priority over R7.
- R9: In quadrant 1, row 011, a zero 6-bit immediate is reserved for every rd. When the immediate is nonzero, rd=0 is a hint and every other rd is legal. That includes rd=2, the stack adjust.
- R10: In quadrant 1, row 001, every halfword is legal with XLEN=32. With XLEN=64, rd=0 is reserved and the rest are legal, including a zero immediate.
- R11: In quadrant 1, row 100, with bits 11:10 = 11 and bit 12 = 1, the result is reserved when bits 6:5 are 10 or 11. Bits 6:5 of 00 or 01 (the word subtract and word add) are legal with XLEN=64 and reserved with XLEN=32. When bit 12 = 0, the result is legal.
- R12: In quadrant 2, row 100, with rs2=0: bit 12=0 and rd=0 is reserved, and every other rd is legal (jump register). Bit 12=1 is legal for any rd (breakpoint or jump-and-link register).
- R13: Every halfword not covered by R2 to R12 is legal. This covers loads, stores, jumps, branches, AND-immediate and the remaining rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_hw | input | 16 | Halfword to classify |
| not_compressed | output | 1 | Low bits are 2'b11; halfword belongs to a 32-bit instruction |
| category | output | 5 | One-hot class: legal, hint, reserved, custom, illegal |
| ntl_hint | output | 1 | Hint is a non-temporal locality form |
| ntl_level | output | 2 | Locality level (rs2−2) when `ntl_hint` is set |
| shift_hint | output | 1 | Hint is a degenerate shift |

## Verification
The bench builds two copies side by side, one with XLEN=32 and one with XLEN=64, and drives both with the same halfwords. This brings the base-width rows into reach at the same time: the custom shifts, the row shared by jump-and-link and word add-immediate, and the word ALU forms. A sweep of all 65,536 halfwords compares both copies against a reference model written from the requirements, so every degenerate operand corner is covered. A directed prefix puts the named corners first so that they show up early in a trace.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

  localparam int CAT_W     = 5;
  localparam int CAT_LEGAL = 0;
  localparam int CAT_HINT  = 1;
  localparam int CAT_RSVD  = 2;
  localparam int CAT_CUST  = 3;
  localparam int CAT_ILL   = 4;
  localparam int HW_W      = 16;
  localparam int LVL_W     = 2;

  typedef struct packed {
    logic [CAT_W-1:0] cat;
    logic             ntl;
    logic [LVL_W-1:0] lvl;
    logic             shf;
  } cpc_res_t;

  // one-hot vector for a class index
  function automatic logic [CAT_W-1:0] cat_vec(input int idx);
    logic [CAT_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  // result carrying only a class, no side flags
  function automatic cpc_res_t mk(input int idx);
    cpc_res_t r;
    r = '0;
    r.cat = cat_vec(idx);
    return r;
  endfunction

  // 6-bit CI-format immediate / shift amount
  function automatic logic [5:0] imm6(input logic [HW_W-1:0] h);
    return {h[12], h[6:2]};
  endfunction

  // shared rule for left and right immediate shifts
  function automatic cpc_res_t shift_cls(input logic [5:0] sh, input logic rd_zero,
                                         input logic rv64);
    cpc_res_t r;
    if (!rv64 && sh[5]) begin
      r = mk(CAT_CUST);
    end else if (rd_zero || (sh == 6'd0)) begin
      r = mk(CAT_HINT);
      r.shf = 1'b1;
    end else begin
      r = mk(CAT_LEGAL);
    end
    return r;
  endfunction

endpackage

// File: rtl/cpc_quad0.sv
module cpc_quad0 import cpc_pkg::*; (
  input  logic [HW_W-1:0] hw,
  output cpc_res_t        res
);

  logic all_zero;
  logic row_rsvd;
  logic spn_zero;

  assign all_zero = (hw == '0);
  assign row_rsvd = (hw[15:13] == 3'b100);
  assign spn_zero = (hw[15:13] == 3'b000) && (hw[12:5] == 8'd0);

  always_comb begin
    if (all_zero)                  res = mk(CAT_ILL);
    else if (row_rsvd || spn_zero) res = mk(CAT_RSVD);
    else                           res = mk(CAT_LEGAL);
  end

endmodule

// File: rtl/cpc_quad1.sv
module cpc_quad1 import cpc_pkg::*; #(
  parameter bit RV64 = 1'b0
) (
  input  logic [HW_W-1:0] hw,
  output cpc_res_t        res
);

  logic [2:0] row;
  logic       rd_z;
  logic       imm_z;
  logic [1:0] alu_sel;
  logic       word_op;

  assign row     = hw[15:13];
  assign rd_z    = (hw[11:7] == 5'd0);
  assign imm_z   = (imm6(hw) == 6'd0);
  assign alu_sel = hw[11:10];
  assign word_op = hw[12] && !hw[6];

  always_comb begin
    res = mk(CAT_LEGAL);
    case (row)
      3'b000: if (rd_z != imm_z) res = mk(CAT_HINT);
      3'b001: if (RV64 && rd_z) res = mk(CAT_RSVD);
      3'b010: if (rd_z) res = mk(CAT_HINT);
      3'b011: begin
        if (imm_z)     res = mk(CAT_RSVD);
        else if (rd_z) res = mk(CAT_HINT);
      end
      3'b100: begin
        case (alu_sel)
          2'b00, 2'b01: res = shift_cls(imm6(hw), 1'b0, RV64);
          2'b11: begin
            if (hw[12] && (!word_op || !RV64)) res = mk(CAT_RSVD);
          end
          default: res = mk(CAT_LEGAL);
        endcase
      end
      default: res = mk(CAT_LEGAL);
    endcase
  end

endmodule

// File: rtl/cpc_quad2.sv
module cpc_quad2 import cpc_pkg::*; #(
  parameter bit RV64 = 1'b0
) (
  input  logic [HW_W-1:0] hw,
  output cpc_res_t        res
);

  logic [2:0] row;
  logic [4:0] rs2;
  logic       rd_z;
  logic       rs2_z;
  logic       ntl_range;

  assign row       = hw[15:13];
  assign rs2       = hw[6:2];
  assign rd_z      = (hw[11:7] == 5'd0);
  assign rs2_z     = (rs2 == 5'd0);
  assign ntl_range = (rs2 >= 5'd2) && (rs2 <= 5'd5);

  always_comb begin
    res = mk(CAT_LEGAL);
    case (row)
      3'b000: res = shift_cls(imm6(hw), rd_z, RV64);
      3'b100: begin
        if (!hw[12]) begin
          if (rd_z) res = rs2_z ? mk(CAT_RSVD) : mk(CAT_HINT);
        end else if (!rs2_z && rd_z) begin
          res = mk(CAT_HINT);
          if (ntl_range) begin
            res.ntl = 1'b1;
            res.lvl = rs2[1:0] - 2'd2;
          end
        end
      end
      default: res = mk(CAT_LEGAL);
    endcase
  end

endmodule

// File: rtl/cpc_classify.sv
module cpc_classify import cpc_pkg::*; #(
  parameter int XLEN = 32
) (
  input  logic [HW_W-1:0]  insn_hw,
  output logic             not_compressed,
  output logic [CAT_W-1:0] category,
  output logic             ntl_hint,
  output logic [LVL_W-1:0] ntl_level,
  output logic             shift_hint
);

  localparam bit IS_RV64 = (XLEN == 64);

  cpc_res_t q0_res;
  cpc_res_t q1_res;
  cpc_res_t q2_res;
  cpc_res_t sel_res;
  logic     quad3;

  cpc_quad0 u_q0 (.hw(insn_hw), .res(q0_res));
  cpc_quad1 #(.RV64(IS_RV64)) u_q1 (.hw(insn_hw), .res(q1_res));
  cpc_quad2 #(.RV64(IS_RV64)) u_q2 (.hw(insn_hw), .res(q2_res));

  assign quad3 = (insn_hw[1:0] == 2'b11);

  always_comb begin
    case (insn_hw[1:0])
      2'b00:   sel_res = q0_res;
      2'b01:   sel_res = q1_res;
      2'b10:   sel_res = q2_res;
      default: sel_res = '0;
    endcase
  end

  assign not_compressed = quad3;
  assign category       = sel_res.cat;
  assign ntl_hint       = sel_res.ntl;
  assign ntl_level      = sel_res.lvl;
  assign shift_hint     = sel_res.shf;

endmodule

// File: rtl/cpc_classify_chk.sv
module cpc_classify_chk import cpc_pkg::*; #(
  parameter int XLEN = 32
) (
  input logic [HW_W-1:0]  insn_hw,
  input logic             not_compressed,
  input logic [CAT_W-1:0] category,
  input logic             ntl_hint,
  input logic [LVL_W-1:0] ntl_level,
  input logic             shift_hint
);

  always_comb begin
    // R1
    one_class_chk: assert (not_compressed || ($countones(category) == 1));
    // R1
    quad3_quiet_chk: assert (!not_compressed ||
      ((category == '0) && !ntl_hint && !shift_hint && (ntl_level == '0)));
    // R2
    zero_illegal_chk: assert ((insn_hw != '0) || category[CAT_ILL]);
    // R2
    illegal_only_zero_chk: assert (!category[CAT_ILL] || (insn_hw == '0));
    // R3
    q0_row4_rsvd_chk: assert (!((insn_hw[1:0] == 2'b00) && (insn_hw[15:13] == 3'b100))
                              || category[CAT_RSVD]);
    // R6
    ntl_is_hint_chk: assert (!ntl_hint || category[CAT_HINT]);
    // R6
    ntl_level_idle_chk: assert (ntl_hint || (ntl_level == '0));
    // R7
    shift_is_hint_chk: assert (!shift_hint || category[CAT_HINT]);
  end

endmodule

bind cpc_classify cpc_classify_chk #(.XLEN(XLEN)) u_chk (
  .insn_hw(insn_hw),
  .not_compressed(not_compressed),
  .category(category),
  .ntl_hint(ntl_hint),
  .ntl_level(ntl_level),
  .shift_hint(shift_hint)
);

// File: tb/cpc_classify_tb.sv
module cpc_classify_tb;

  typedef struct {
    bit       ncmp;
    int       cat;
    bit       ntl;
    bit [1:0] lvl;
    bit       shf;
    string    req;
  } exp_t;

  typedef struct {
    bit [15:0] h;
    exp_t      e32;
    exp_t      e64;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] hw = 16'h0000;
  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  item_t sb_q[$];

  logic       nc32, nc64, ntl32, ntl64, sh32, sh64;
  logic [4:0] cat32, cat64;
  logic [1:0] lv32, lv64;

  always #10 clk = ~clk;

  cpc_classify #(.XLEN(32)) u_dut (
    .insn_hw(hw), .not_compressed(nc32), .category(cat32),
    .ntl_hint(ntl32), .ntl_level(lv32), .shift_hint(sh32));

  cpc_classify #(.XLEN(64)) u_dut_rv64 (
    .insn_hw(hw), .not_compressed(nc64), .category(cat64),
    .ntl_hint(ntl64), .ntl_level(lv64), .shift_hint(sh64));

  // reference model restated from the requirements
  function automatic exp_t model(bit [15:0] h, bit rv64);
    exp_t e;
    bit [4:0] d  = h[11:7];
    bit [4:0] s  = h[6:2];
    bit [5:0] im = {h[12], h[6:2]};
    bit [4:0] code = {h[1:0], h[15:13]};
    e.ncmp = 0; e.cat = 0; e.ntl = 0; e.lvl = 0; e.shf = 0; e.req = "R13";
    if (h[1:0] == 2'b11) begin
      e.ncmp = 1; e.cat = -1; e.req = "R1";
      return e;
    end
    if (h == 16'h0) begin
      e.cat = 4; e.req = "R2";
      return e;
    end
    case (code)
      5'b00_000: if (h[12:5] == 0) begin e.cat = 2; e.req = "R3"; end
      5'b00_100: begin e.cat = 2; e.req = "R3"; end
      5'b01_000: begin
        e.req = "R4";
        if (d == 0 && im == 0) e.cat = 0;
        else if (d == 0 || im == 0) e.cat = 1;
      end
      5'b01_001: begin e.req = "R10"; if (rv64 && d == 0) e.cat = 2; end
      5'b01_010: begin e.req = "R5"; if (d == 0) e.cat = 1; end
      5'b01_011: begin
        e.req = "R9";
        if (im == 0) e.cat = 2;
        else if (d == 0) e.cat = 1;
      end
      5'b01_100: begin
        if (h[11] == 1'b0) begin
          if (!rv64 && h[12]) begin e.cat = 3; e.req = "R8"; end
          else if (im == 0) begin e.cat = 1; e.shf = 1; e.req = "R7"; end
        end else if (h[10] == 1'b1) begin
          e.req = "R11";
          if (h[12] && (h[6] || !rv64)) e.cat = 2;
        end
      end
      5'b10_000: begin
        if (!rv64 && h[12]) begin e.cat = 3; e.req = "R8"; end
        else if (d == 0 || im == 0) begin e.cat = 1; e.shf = 1; e.req = "R7"; end
      end
      5'b10_100: begin
        if (s == 0) begin
          e.req = "R12";
          if (!h[12] && d == 0) e.cat = 2;
        end else if (d == 0) begin
          e.cat = 1; e.req = "R5";
          if (h[12] && s >= 2 && s <= 5) begin
            e.ntl = 1; e.lvl = 2'(s - 2); e.req = "R6";
          end
        end
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic apply(input bit [15:0] h);
    item_t it;
    @(posedge clk);
    hw <= h;
    it.h = h;
    it.e32 = model(h, 1'b0);
    it.e64 = model(h, 1'b1);
    sb_q.push_back(it);
  endtask

  task automatic compare(input string tag, input bit [15:0] h, input exp_t e,
                         input logic nc, input logic [4:0] c, input logic n,
                         input logic [1:0] l, input logic s);
    logic [4:0] ev;
    ev = (e.cat < 0) ? 5'd0 : (5'd1 << e.cat);
    n_chk++;
    if (nc !== e.ncmp || c !== ev || n !== e.ntl || l !== e.lvl || s !== e.shf) begin
      n_bad++;
      $display("FAIL %s %s hw=%h actual nc=%b cat=%b ntl=%b lvl=%0d shf=%b expected nc=%b cat=%b ntl=%b lvl=%0d shf=%b",
               e.req, tag, h, nc, c, n, l, s, e.ncmp, ev, e.ntl, e.lvl, e.shf);
    end
  endtask

  // monitor: pop one expected item per cycle, away from the driving edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      compare("xlen32", it.h, it.e32, nc32, cat32, ntl32, lv32, sh32);
      compare("xlen64", it.h, it.e64, nc64, cat64, ntl64, lv64, sh64);
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R2 reset-time input: all-zero halfword
    apply(16'h0000);
    // R1 32-bit instruction halves
    apply(16'h0003); apply(16'hFFFF);
    // R3 reserved row and zero stack-pointer offset
    apply(16'h8000); apply(16'h0004);
    // R4 no-op, immediate hints
    apply(16'h0001); apply(16'h0005); apply(16'h0081);
    // R5 load-immediate, move and add to x0
    apply(16'h4005); apply(16'h800A); apply(16'h901A);
    // R6 locality levels 0 and 3
    apply(16'h900A); apply(16'h9016);
    // R7 and R8 shifts
    apply(16'h0082); apply(16'h1002); apply(16'h8001); apply(16'h9005);
    // R9 stack adjust and upper-immediate
    apply(16'h6101); apply(16'h6105); apply(16'h6001); apply(16'h6081);
    // R10 shared row
    apply(16'h2001); apply(16'h2081);
    // R11 word ALU
    apply(16'h9C01); apply(16'h9C21); apply(16'h9C41);
    // R12 jump register and breakpoint
    apply(16'h8002); apply(16'h9002); apply(16'h8082);
    // R13 full sweep, every requirement by code point
    for (int i = 0; i < 65536; i++) apply(16'(i));
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule